// File: doc/BRIEF.md
# BCH Error Location Mapper

This block sits after a BCH error-locator stage and turns its output, a list of bit positions for one sector, into correction records. A position counts bits from the far end of the combined data-plus-ECC codeword, so the mapper reverses byte order. Each record says whether to flip a bit in the data area, flip a bit in the stored ECC bytes, or report that the location is outside the codeword. Two strengths are supported. The 8-error mode uses 14 ECC bytes, the last of them reserved. The 16-error mode uses 26 ECC bytes.

A job starts with a one-cycle `start` pulse. The pulse carries the mode, the computed and stored ECC bytes, and the number of positions that will follow. Two checks come first. If the computed ECC is all zero, no error is present. If the stored ECC is all ones, the sector is an erased page. In either case the job ends at once and accepts no positions. Otherwise the block takes one position per cycle over a valid/ready handshake and presents one record in the following cycle. It ends the job with a one-cycle `done` that carries the final result. A combinational output gives the computed ECC bytes in the reversed order that the locator stage expects.

Top module: `bch_err_mapper`

## Requirements
- R1: After reset, `pos_ready`, `rec_valid` and `done` are all 0.
- R2: On `start`, if every computed ECC byte in the mode's range is 0x00 (bytes 0..13 in 8-error mode, 0..25 in 16-error mode), the next cycle shows `done`=1, `done_nosyn`=1, `done_err`=0 and `done_cnt`=0. No position is accepted and no record is produced.
- R3: If R2 does not apply and every stored ECC byte in the mode's range is 0xFF, the next cycle shows `done`=1, `done_erased`=1, `done_err`=0 and `done_cnt`=0. No position is accepted.
- R4: If neither screen applies and `err_cnt` exceeds 8 (8-error mode, `mode_hi`=0) or 16 (`mode_hi`=1), the next cycle shows `done`=1, `done_err`=1 and `done_cnt`=0. No position is accepted.
- R5: `ecc_rev` byte i (bits 8i+7..8i) equals `calc_ecc` byte 12-i for i<13 and byte i otherwise in 8-error mode. In 16-error mode it equals byte 25-i.
- R6: The limit L is SECTOR_BYTES+13 in 8-error mode and SECTOR_BYTES+26 in 16-error mode. For a position p with p/8 < L, let the index be L-1-(p/8). If the index is below SECTOR_BYTES, the record has `rec_tgt`=0 (data), `rec_byte`=index and `rec_bit`=p mod 8.
- R7: An index from SECTOR_BYTES up to L-1 gives `rec_tgt`=1 (ECC byte), `rec_byte`=index-SECTOR_BYTES and `rec_bit`=p mod 8.
- R8: A position with p/8 ≥ L gives `rec_tgt`=2 (invalid), `rec_byte`=0 and `rec_bit`=p mod 8. It makes the job end with `done_err`=1.
- R9: `pos_ready` is 1 only while positions are outstanding. Exactly `err_cnt` positions are accepted. Each accepted position gives one record with `rec_valid`=1 in the next cycle, and `rec_valid` is 0 in every other cycle.
- R10: `done` is 1 for exactly one cycle, the cycle that presents the last record (or the cycle after `start` when `err_cnt`=0). `done_cnt` is `err_cnt` when no invalid location was seen and 0 otherwise.
- R11: ECC bytes 14..25 have no effect on either screen in 8-error mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (sampled when idle) |
| mode_hi | input | 1 | 0: 8-error mode, 1: 16-error mode |
| calc_ecc | input | 8*ECC16_BYTES | Computed ECC, byte i at bits 8i+7..8i |
| stored_ecc | input | 8*ECC16_BYTES | ECC read from the spare area |
| err_cnt | input | CNT_W | Number of positions that will follow |
| ecc_rev | output | 8*ECC16_BYTES | Computed ECC in reversed byte order |
| pos_valid | input | 1 | Position offered |
| pos_ready | output | 1 | Position accepted this cycle when valid |
| pos | input | POS_W | Error bit position |
| rec_valid | output | 1 | Record valid |
| rec_tgt | output | 2 | 0 data, 1 ECC byte, 2 invalid |
| rec_byte | output | BYTE_W | Byte index within the target |
| rec_bit | output | 3 | Bit index within the byte |
| done | output | 1 | Job finished (one cycle) |
| done_err | output | 1 | Invalid location or count over limit |
| done_cnt | output | CNT_W | Number of corrections applied |
| done_nosyn | output | 1 | Job ended by the all-zero screen |
| done_erased | output | 1 | Job ended by the erased-page screen |

## Verification
The bench builds the mapper with SECTOR_BYTES=16 and POS_W=10 and keeps the default ECC byte counts and limits. A 16-byte sector makes the codeword short: 29 bytes in 8-error mode and 42 bytes in 16-error mode. Every bit position of both codewords, plus two bytes past each limit, can then be streamed in full-size batches, so each data, ECC and invalid mapping is compared with arithmetic in the bench. Both screens, the ignored upper bytes in 8-error mode, the count limits and the reversal of all 26 bytes in both modes are checked at the ports.

// File: rtl/bch_map_pkg.sv
package bch_map_pkg;
   typedef enum logic [1:0] {
      TGT_DATA = 2'd0,
      TGT_ECC  = 2'd1,
      TGT_BAD  = 2'd2
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } st_e;
endpackage

// File: rtl/bch_map_screen.sv
module bch_map_screen #(
   parameter int ECC8_BYTES  = 14,
   parameter int ECC16_BYTES = 26,
   localparam int ECCW = ECC16_BYTES * 8
) (
   input  logic            mode_hi,
   input  logic [ECCW-1:0] calc_ecc,
   input  logic [ECCW-1:0] stored_ecc,
   output logic            all_zero,
   output logic            all_ones
);
   logic [ECC16_BYTES-1:0] zero_ok;
   logic [ECC16_BYTES-1:0] ones_ok;

   for (genvar i = 0; i < ECC16_BYTES; i++) begin : g_byte
      if (i < ECC8_BYTES) begin : g_common
         assign zero_ok[i] = (calc_ecc[8*i +: 8] == 8'h00);
         assign ones_ok[i] = (stored_ecc[8*i +: 8] == 8'hFF);
      end else begin : g_wide_only
         assign zero_ok[i] = !mode_hi || (calc_ecc[8*i +: 8] == 8'h00);
         assign ones_ok[i] = !mode_hi || (stored_ecc[8*i +: 8] == 8'hFF);
      end
   end

   assign all_zero = &zero_ok;
   assign all_ones = &ones_ok;
endmodule

// File: rtl/bch_map_reverse.sv
module bch_map_reverse #(
   parameter int ECC8_USED   = 13,
   parameter int ECC16_BYTES = 26,
   localparam int ECCW = ECC16_BYTES * 8
) (
   input  logic            mode_hi,
   input  logic [ECCW-1:0] calc_ecc,
   output logic [ECCW-1:0] ecc_rev
);
   for (genvar i = 0; i < ECC16_BYTES; i++) begin : g_byte
      localparam int SRC_LO = (i < ECC8_USED) ? (ECC8_USED - 1 - i) : i;
      localparam int SRC_HI = ECC16_BYTES - 1 - i;
      assign ecc_rev[8*i +: 8] = mode_hi ? calc_ecc[8*SRC_HI +: 8]
                                         : calc_ecc[8*SRC_LO +: 8];
   end
endmodule

// File: rtl/bch_map_locate.sv
module bch_map_locate
   import bch_map_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ECC8_USED    = 13,
   parameter int ECC16_BYTES  = 26,
   parameter int POS_W        = 13,
   parameter int BYTE_W       = 10
) (
   input  logic              mode_hi,
   input  logic [POS_W-1:0]  pos,
   output tgt_e              tgt,
   output logic [BYTE_W-1:0] byte_idx,
   output logic [2:0]        bit_idx
);
   localparam logic [31:0] LIM_LO = 32'(SECTOR_BYTES + ECC8_USED);
   localparam logic [31:0] LIM_HI = 32'(SECTOR_BYTES + ECC16_BYTES);
   localparam logic [31:0] SECT   = 32'(SECTOR_BYTES);

   logic [31:0] lim;
   logic [31:0] quot;
   logic [31:0] idx;

   always_comb begin
      lim      = mode_hi ? LIM_HI : LIM_LO;
      quot     = 32'(pos >> 3);
      idx      = lim - 32'd1 - quot;
      bit_idx  = pos[2:0];
      if (quot >= lim) begin
         tgt      = TGT_BAD;
         byte_idx = '0;
      end else if (idx < SECT) begin
         tgt      = TGT_DATA;
         byte_idx = BYTE_W'(idx);
      end else begin
         tgt      = TGT_ECC;
         byte_idx = BYTE_W'(idx - SECT);
      end
   end
endmodule

// File: rtl/bch_err_mapper.sv
module bch_err_mapper
   import bch_map_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ECC8_BYTES   = 14,
   parameter int ECC8_USED    = 13,
   parameter int ECC16_BYTES  = 26,
   parameter int T8           = 8,
   parameter int T16          = 16,
   parameter int POS_W        = 13,
   localparam int ECCW   = ECC16_BYTES * 8,
   localparam int BYTE_W = $clog2(SECTOR_BYTES + ECC16_BYTES),
   localparam int CNT_W  = $clog2(T16 + 1) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_hi,
   input  logic [ECCW-1:0]   calc_ecc,
   input  logic [ECCW-1:0]   stored_ecc,
   input  logic [CNT_W-1:0]  err_cnt,
   output logic [ECCW-1:0]   ecc_rev,
   input  logic              pos_valid,
   output logic              pos_ready,
   input  logic [POS_W-1:0]  pos,
   output logic              rec_valid,
   output logic [1:0]        rec_tgt,
   output logic [BYTE_W-1:0] rec_byte,
   output logic [2:0]        rec_bit,
   output logic              done,
   output logic              done_err,
   output logic [CNT_W-1:0]  done_cnt,
   output logic              done_nosyn,
   output logic              done_erased
);
   if (ECC8_USED >= ECC8_BYTES || ECC8_BYTES > ECC16_BYTES || T8 > T16 ||
       POS_W < 4 || SECTOR_BYTES < 1) begin : g_bad_cfg
      $error("bch_err_mapper: inconsistent parameters");
   end

   localparam logic [CNT_W-1:0] MAX_LO = CNT_W'(T8);
   localparam logic [CNT_W-1:0] MAX_HI = CNT_W'(T16);

   st_e               st_q;
   logic              mode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  rem_q;
   logic              err_q;
   logic              nosyn_q;
   logic              erased_q;
   logic              rv_q;
   tgt_e              tgt_q;
   logic [BYTE_W-1:0] byte_q;
   logic [2:0]        bit_q;

   logic              scr_zero;
   logic              scr_ones;
   logic              over;
   logic              acc;
   tgt_e              loc_tgt;
   logic [BYTE_W-1:0] loc_byte;
   logic [2:0]        loc_bit;

   bch_map_screen #(
      .ECC8_BYTES (ECC8_BYTES),
      .ECC16_BYTES(ECC16_BYTES)
   ) u_screen (
      .mode_hi   (mode_hi),
      .calc_ecc  (calc_ecc),
      .stored_ecc(stored_ecc),
      .all_zero  (scr_zero),
      .all_ones  (scr_ones)
   );

   bch_map_reverse #(
      .ECC8_USED  (ECC8_USED),
      .ECC16_BYTES(ECC16_BYTES)
   ) u_reverse (
      .mode_hi (mode_hi),
      .calc_ecc(calc_ecc),
      .ecc_rev (ecc_rev)
   );

   bch_map_locate #(
      .SECTOR_BYTES(SECTOR_BYTES),
      .ECC8_USED   (ECC8_USED),
      .ECC16_BYTES (ECC16_BYTES),
      .POS_W       (POS_W),
      .BYTE_W      (BYTE_W)
   ) u_locate (
      .mode_hi (mode_q),
      .pos     (pos),
      .tgt     (loc_tgt),
      .byte_idx(loc_byte),
      .bit_idx (loc_bit)
   );

   assign over      = err_cnt > (mode_hi ? MAX_HI : MAX_LO);
   assign pos_ready = (st_q == ST_RUN);
   assign acc       = pos_valid && pos_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         mode_q   <= 1'b0;
         cnt_q    <= '0;
         rem_q    <= '0;
         err_q    <= 1'b0;
         nosyn_q  <= 1'b0;
         erased_q <= 1'b0;
         rv_q     <= 1'b0;
         tgt_q    <= TGT_DATA;
         byte_q   <= '0;
         bit_q    <= '0;
      end else begin
         rv_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  mode_q   <= mode_hi;
                  cnt_q    <= err_cnt;
                  rem_q    <= err_cnt;
                  nosyn_q  <= scr_zero;
                  erased_q <= !scr_zero && scr_ones;
                  err_q    <= !scr_zero && !scr_ones && over;
                  if (scr_zero || scr_ones || over || err_cnt == '0)
                     st_q <= ST_FIN;
                  else
                     st_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (acc) begin
                  rv_q   <= 1'b1;
                  tgt_q  <= loc_tgt;
                  byte_q <= loc_byte;
                  bit_q  <= loc_bit;
                  rem_q  <= rem_q - 1'b1;
                  if (loc_tgt == TGT_BAD)
                     err_q <= 1'b1;
                  if (rem_q == CNT_W'(1))
                     st_q <= ST_FIN;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rec_valid   = rv_q;
   assign rec_tgt     = tgt_q;
   assign rec_byte    = byte_q;
   assign rec_bit     = bit_q;
   assign done        = (st_q == ST_FIN);
   assign done_err    = err_q;
   assign done_cnt    = (err_q || nosyn_q || erased_q) ? '0 : cnt_q;
   assign done_nosyn  = nosyn_q;
   assign done_erased = erased_q;
endmodule

// File: rtl/bch_err_mapper_chk.sv
module bch_err_mapper_chk #(
   parameter int SECTOR_BYTES = 512,
   parameter int ECC16_BYTES  = 26,
   parameter int BYTE_W       = 10,
   parameter int CNT_W        = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pos_valid,
   input logic              pos_ready,
   input logic              rec_valid,
   input logic [1:0]        rec_tgt,
   input logic [BYTE_W-1:0] rec_byte,
   input logic              done,
   input logic              done_err,
   input logic [CNT_W-1:0]  done_cnt,
   input logic              done_nosyn,
   input logic              done_erased
);
   AST_REC_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && pos_ready) |=> rec_valid); // R9
   AST_NO_STRAY_REC: assert property (@(posedge clk) disable iff (!rst_n)
      !(pos_valid && pos_ready) |=> !rec_valid); // R9
   AST_TGT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> rec_tgt != 2'd3); // R8
   AST_DATA_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_tgt == 2'd0) |-> (32'(rec_byte) < 32'(SECTOR_BYTES))); // R6
   AST_ECC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_tgt == 2'd1) |-> (32'(rec_byte) < 32'(ECC16_BYTES))); // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_ERR_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> done_cnt == '0); // R10
   AST_SCREEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(done_nosyn && done_erased)); // R3
   AST_SCREEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (done_nosyn || done_erased)) |-> (!done_err && done_cnt == '0)); // R2
   AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !pos_ready); // R9
endmodule

bind bch_err_mapper bch_err_mapper_chk #(
   .SECTOR_BYTES(SECTOR_BYTES),
   .ECC16_BYTES (ECC16_BYTES),
   .BYTE_W      (BYTE_W),
   .CNT_W       (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pos_valid  (pos_valid),
   .pos_ready  (pos_ready),
   .rec_valid  (rec_valid),
   .rec_tgt    (rec_tgt),
   .rec_byte   (rec_byte),
   .done       (done),
   .done_err   (done_err),
   .done_cnt   (done_cnt),
   .done_nosyn (done_nosyn),
   .done_erased(done_erased)
);

// File: tb/test_bch_err_mapper.sv
`timescale 1ns/1ps
module test_bch_err_mapper;
   localparam int SB     = 16;
   localparam int E8     = 14;
   localparam int E8U    = 13;
   localparam int E16    = 26;
   localparam int PW     = 10;
   localparam int ECCW   = E16 * 8;
   localparam int BYTE_W = $clog2(SB + E16);
   localparam int CNT_W  = $clog2(16 + 1) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              mode_hi = 1'b0;
   logic [ECCW-1:0]   calc_ecc = '0;
   logic [ECCW-1:0]   stored_ecc = '0;
   logic [CNT_W-1:0]  err_cnt = '0;
   logic [ECCW-1:0]   ecc_rev;
   logic              pos_valid = 1'b0;
   logic              pos_ready;
   logic [PW-1:0]     pos = '0;
   logic              rec_valid;
   logic [1:0]        rec_tgt;
   logic [BYTE_W-1:0] rec_byte;
   logic [2:0]        rec_bit;
   logic              done;
   logic              done_err;
   logic [CNT_W-1:0]  done_cnt;
   logic              done_nosyn;
   logic              done_erased;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   bch_err_mapper #(
      .SECTOR_BYTES(SB), .ECC8_BYTES(E8), .ECC8_USED(E8U),
      .ECC16_BYTES(E16), .T8(8), .T16(16), .POS_W(PW)
   ) i_bch_err_mapper (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_hi(mode_hi),
      .calc_ecc(calc_ecc), .stored_ecc(stored_ecc), .err_cnt(err_cnt),
      .ecc_rev(ecc_rev), .pos_valid(pos_valid), .pos_ready(pos_ready),
      .pos(pos), .rec_valid(rec_valid), .rec_tgt(rec_tgt),
      .rec_byte(rec_byte), .rec_bit(rec_bit), .done(done),
      .done_err(done_err), .done_cnt(done_cnt), .done_nosyn(done_nosyn),
      .done_erased(done_erased)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_job(input logic m, input int cnt,
                            input logic [ECCW-1:0] c, input logic [ECCW-1:0] s);
      @(negedge clk);
      mode_hi    = m;
      err_cnt    = CNT_W'(cnt);
      calc_ecc   = c;
      stored_ecc = s;
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // job that must end at once without taking positions
   task automatic early_end(input string req, input int nosyn, input int erased,
                            input int err);
      chk(req, done, 1);
      chk(req, done_nosyn, nosyn);
      chk(req, done_erased, erased);
      chk(req, done_err, err);
      chk(req, done_cnt, 0);
      chk(req, pos_ready, 0);
      pos_valid = 1'b1;
      pos       = '0;
      @(negedge clk);
      chk(req, rec_valid, 0);
      chk(req, done, 0);
      chk(req, pos_ready, 0);
      pos_valid = 1'b0;
   endtask

   task automatic expect_loc(input logic m, input int p, output int tgt,
                             output int byt, output int bt);
      int lim;
      int q;
      int idx;
      lim = SB + (m ? E16 : E8U);
      q   = p / 8;
      bt  = p % 8;
      if (q >= lim) begin
         tgt = 2; byt = 0;
      end else begin
         idx = lim - 1 - q;
         if (idx < SB) begin tgt = 0; byt = idx; end
         else begin tgt = 1; byt = idx - SB; end
      end
   endtask

   task automatic run_batch(input logic m, input int base, input int cnt,
                            input int gap_every);
      logic [ECCW-1:0] c;
      int any_bad;
      int et;
      int eb;
      int ei;
      string req;
      c = '0;
      c[7:0] = 8'h01;
      any_bad = 0;
      start_job(m, cnt, c, '0);
      for (int k = 0; k < cnt; k++) begin
         if (gap_every > 0 && k > 0 && (k % gap_every) == 0) begin
            pos_valid = 1'b0;
            @(negedge clk);
            chk("R9", rec_valid, 0);
         end
         pos_valid = 1'b1;
         pos       = PW'(base + k);
         chk("R9", pos_ready, 1);
         @(negedge clk);
         expect_loc(m, base + k, et, eb, ei);
         if (et == 2) any_bad = 1;
         req = (et == 0) ? "R6" : ((et == 1) ? "R7" : "R8");
         chk("R9", rec_valid, 1);
         chk(req, rec_tgt, et);
         chk(req, rec_byte, eb);
         chk(req, rec_bit, ei);
         if (k == cnt - 1) begin
            pos_valid = 1'b0;
            chk("R10", done, 1);
            chk("R8", done_err, any_bad);
            chk("R10", done_cnt, any_bad ? 0 : cnt);
         end else begin
            chk("R10", done, 0);
         end
      end
      @(negedge clk);
      chk("R10", done, 0);
      chk("R9", pos_ready, 0);
      chk("R9", rec_valid, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [ECCW-1:0] c;
      logic [ECCW-1:0] s;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", pos_ready, 0);
      chk("R1", rec_valid, 0);
      chk("R1", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", done, 0);

      // R5: reversal in both modes
      for (int i = 0; i < E16; i++) calc_ecc[8*i +: 8] = 8'(i + 1);
      mode_hi = 1'b0;
      #1;
      for (int i = 0; i < E16; i++)
         chk("R5", ecc_rev[8*i +: 8], (i < E8U) ? (E8U - i) : (i + 1));
      mode_hi = 1'b1;
      #1;
      for (int i = 0; i < E16; i++)
         chk("R5", ecc_rev[8*i +: 8], E16 - i);

      // R2: all-zero computed ECC, both modes
      start_job(1'b0, 5, '0, '0);
      early_end("R2", 1, 0, 0);
      start_job(1'b1, 5, '0, '1);
      early_end("R2", 1, 0, 0);

      // R3: erased page
      c = '0; c[15:8] = 8'h5A;
      start_job(1'b0, 3, c, '1);
      early_end("R3", 0, 1, 0);
      start_job(1'b1, 3, c, '1);
      early_end("R3", 0, 1, 0);

      // R11: upper bytes ignored in 8-error mode
      c = '0; c[8*20 +: 8] = 8'h33;
      start_job(1'b0, 4, c, '0);
      early_end("R11", 1, 0, 0);
      s = '1; s[8*20 +: 8] = 8'h00;
      c = '0; c[7:0] = 8'h01;
      start_job(1'b0, 4, c, s);
      early_end("R11", 0, 1, 0);
      // same upper byte counts in 16-error mode: no screen, zero count
      c = '0; c[8*20 +: 8] = 8'h33;
      start_job(1'b1, 0, c, '0);
      early_end("R10", 0, 0, 0);

      // R4: count over the mode limit
      c = '0; c[7:0] = 8'h01;
      start_job(1'b0, 9, c, '0);
      early_end("R4", 0, 0, 1);
      start_job(1'b1, 17, c, '0);
      early_end("R4", 0, 0, 1);

      // R6/R7/R8 sweeps: every position up to two bytes past the limit
      for (int b = 0; b < (SB + E8U + 2) * 8; b += 8)
         run_batch(1'b0, b, 8, (b % 16 == 0) ? 3 : 0);
      for (int b = 0; b < (SB + E16 + 2) * 8; b += 16)
         run_batch(1'b1, b, 16, (b % 32 == 0) ? 5 : 0);
      // short batch straddling the invalid boundary
      run_batch(1'b1, (SB + E16) * 8 - 2, 3, 1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule